// File: doc/BRIEF.md
# Page Write Programming Sequencer

This block sits between the serial command decoder of a small word-organised non-volatile store and its register array. The decoder gives it three strobes: one for a single-word write, one for a page write and one for a write-all. Each strobe comes with a start address. The decoder then passes each data word as it finishes shifting in. The sequencer holds up to four words and tracks the address each one targets. For every word it asks the protection block whether that address may be written.

After the last bit of a word is sampled, chip select must fall before the next serial clock rising edge. If it does, the block runs a set of eligibility checks, and if they all pass it starts a self-timed programming cycle. During that cycle it raises busy and drives the array write port from the buffered words. It keeps busy high for a fixed, parameterised number of system clock cycles. The serial clock may stop during the cycle without any effect. Commands that arrive while busy is high are discarded.

Top module: `pw_prog_seq`

## Requirements
- R1: After reset, busy and mem_we are low.
- R2: A single-word write programs its one data word at the command address when started.
- R3: A page write programs each received word (at most PAGE_WORDS=4) at consecutive addresses. Only the two low address bits advance, and they wrap modulo 4. The upper address bits stay at those of the start address.
- R4: A write-all programs every location with its data word, but only when prot_clear is high at the moment chip select falls. Otherwise nothing is written.
- R5: A cycle starts only when cs is seen low after an accepted word, with no sclk_rise seen since that word. If cs falls before the last word completes, or after a further sclk_rise, nothing is programmed.
- R6: No cycle starts unless both wen_latch and wen_pin are high when cs falls.
- R7: A page or single-word write is rejected as a whole if chk_deny was high for any of its word addresses.
- R8: Busy rises on the clock after the qualifying cs fall and stays high for exactly PROG_CYCLES (80) cycles. All array writes happen inside that window, without any sclk_rise.
- R9: While busy is high, command strobes, words and cs activity are ignored. No second cycle and no write results from them.
- R10: Words beyond the command's limit are not stored: one word for single-word and write-all commands, four for a page write. Such a word does not reopen the window, so a fifth page word cancels the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_word | input | 1 | Decoded single-word write strobe |
| cmd_page | input | 1 | Decoded page write strobe |
| cmd_all | input | 1 | Decoded write-all strobe |
| cmd_addr | input | AW | Start address of the command |
| word_valid | input | 1 | A data word has completed shifting in |
| word_data | input | DW | The completed data word |
| sclk_rise | input | 1 | One-cycle pulse per serial clock rising edge |
| cs | input | 1 | Chip select level |
| wen_latch | input | 1 | Write-enable latch state |
| wen_pin | input | 1 | Write-enable pin level |
| prot_clear | input | 1 | Protection register is in its cleared state |
| chk_addr | output | AW | Address of the next word, sent to the protection block |
| chk_deny | input | 1 | Protection block answer: chk_addr is protected |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |

## Verification
Some properties are checked by assertions on every cycle. Array writes happen only while busy is high. Every busy interval lasts exactly the programmed count. A cycle begins only after chip select is low with no serial clock edge, and only with both write enables present. Inside a page, the upper address bits of consecutive writes stay the same. No start is attempted while busy.

Other behaviour only the bench scenarios can show. This covers the exact set of words and addresses written, with wrap inside the page. It also covers whole-command rejection when one address is protected, the write-all gate on the cleared protection state, and the early and late chip-select cases. Cancellation by a surplus word is shown the same way. The bench compares a full mirror of the array against expected contents after every command.

// File: rtl/pw_pkg.sv
// Shared types for the page write programming sequencer.
package pw_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_WORD = 2'd1,
        OP_PAGE = 2'd2,
        OP_ALL  = 2'd3
    } pw_op_e;
endpackage

// File: rtl/pw_collect.sv
// Command collector: latches the command kind and start address. Stores
// incoming words in page slots and accumulates a reject flag from the
// protection answer for each word address.
// Assumes PW is a power of two of at least 2 and AW > log2(PW).
module pw_collect
    import pw_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int PW = 4,
    localparam int LW = $clog2(PW),
    localparam int CW = LW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  pw_op_e                 start_op,
    input  logic [AW-1:0]          start_addr,
    input  logic                   word_valid,
    input  logic [DW-1:0]          word_data,
    input  logic                   deny,
    input  logic                   drop,
    output pw_op_e                 op,
    output logic [AW-1:0]          base,
    output logic [CW-1:0]          count,
    output logic [PW-1:0][DW-1:0]  words,
    output logic                   reject,
    output logic [AW-1:0]          cur_addr,
    output logic                   word_acc
);
    logic [CW-1:0] limit;

    // Word limit per command kind; accept only while below it.
    always_comb begin
        limit    = (op == OP_PAGE) ? CW'(PW) : CW'(1);
        word_acc = word_valid && (op != OP_IDLE) && (count < limit);
        cur_addr = {base[AW-1:LW], base[LW-1:0] + count[LW-1:0]};
    end

    // Command state: kind, base address, word count, reject flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op     <= OP_IDLE;
            base   <= '0;
            count  <= '0;
            reject <= 1'b0;
        end else if (start) begin
            op     <= start_op;
            base   <= start_addr;
            count  <= '0;
            reject <= 1'b0;
        end else if (drop) begin
            op     <= OP_IDLE;
        end else if (word_acc) begin
            count <= count + CW'(1);
            if (deny && op != OP_ALL)
                reject <= 1'b1;
        end
    end

    for (genvar g = 0; g < PW; g++) begin : g_slot
        logic [DW-1:0] slot_q;
        // One buffered word per slot, written when its turn comes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (word_acc && count[LW-1:0] == LW'(g))
                slot_q <= word_data;
        end
        assign words[g] = slot_q;
    end
endmodule

// File: rtl/pw_window.sv
// Chip-select window tracker: opens after an accepted word and closes
// on the next serial clock edge. A chip-select fall ends the command
// and is a start request only while the window is open.
// Assumes sclk_rise is a single-cycle pulse in the system clock domain.
module pw_window (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic word_acc,
    input  logic sclk_rise,
    input  logic cs,
    input  logic active,
    input  logic busy,
    output logic launch_try,
    output logic drop
);
    logic armed_q;

    // Window flag: set by a finished word, cleared by a clock edge or deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (start || busy)
            armed_q <= 1'b0;
        else if (word_acc)
            armed_q <= 1'b1;
        else if (sclk_rise || !cs)
            armed_q <= 1'b0;
    end

    // Deselect ends any open command; it starts one only inside the window.
    always_comb begin
        drop       = active && !cs && !start;
        launch_try = drop && armed_q && !sclk_rise;
    end
endmodule

// File: rtl/pw_timer.sv
// Self-timed programming engine: on launch it holds busy for PROG_CYCLES
// system clocks and writes the buffered words (or every location for
// write-all) one per cycle from the first busy cycle.
// Assumes PROG_CYCLES >= 2**AW so that a write-all completes in time.
module pw_timer
    import pw_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int PW          = 4,
    parameter int PROG_CYCLES = 80,
    localparam int LW    = $clog2(PW),
    localparam int CW    = LW + 1,
    localparam int DEPTH = 1 << AW,
    localparam int IW    = AW + 1,
    localparam int TW    = $clog2(PROG_CYCLES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   launch,
    input  pw_op_e                 op,
    input  logic [AW-1:0]          base,
    input  logic [CW-1:0]          count,
    input  logic [PW-1:0][DW-1:0]  words,
    output logic                   busy,
    output logic                   all_mode,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata
);
    logic [TW-1:0] tcnt_q;
    logic [IW-1:0] widx_q;
    logic [IW-1:0] nwr_q;
    logic [AW-1:0] base_q;

    // Cycle timer and write index, loaded on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            all_mode <= 1'b0;
            tcnt_q   <= '0;
            widx_q   <= '0;
            nwr_q    <= '0;
            base_q   <= '0;
        end else if (launch && !busy) begin
            busy     <= 1'b1;
            all_mode <= (op == OP_ALL);
            tcnt_q   <= TW'(PROG_CYCLES - 1);
            widx_q   <= '0;
            nwr_q    <= (op == OP_ALL) ? IW'(DEPTH) : IW'(count);
            base_q   <= base;
        end else if (busy) begin
            if (mem_we)
                widx_q <= widx_q + IW'(1);
            if (tcnt_q == '0)
                busy <= 1'b0;
            else
                tcnt_q <= tcnt_q - TW'(1);
        end
    end

    // Array port: page addresses wrap in the low bits; write-all sweeps all.
    always_comb begin
        mem_we    = busy && (widx_q < nwr_q);
        mem_addr  = all_mode ? widx_q[AW-1:0]
                             : {base_q[AW-1:LW], base_q[LW-1:0] + widx_q[LW-1:0]};
        mem_wdata = all_mode ? words[0] : words[widx_q[LW-1:0]];
    end
endmodule

// File: rtl/pw_prog_seq.sv
// Top of the page write programming sequencer. Takes decoded write
// commands and serial words, gates the start of a self-timed cycle on
// the chip-select window, write enables and protection, then drives the
// array write port. Assumes all inputs are synchronous to clk.
module pw_prog_seq
    import pw_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int PAGE_WORDS  = 4,
    parameter int PROG_CYCLES = 80,
    localparam int LW = $clog2(PAGE_WORDS),
    localparam int CW = LW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_word,
    input  logic           cmd_page,
    input  logic           cmd_all,
    input  logic [AW-1:0]  cmd_addr,
    input  logic           word_valid,
    input  logic [DW-1:0]  word_data,
    input  logic           sclk_rise,
    input  logic           cs,
    input  logic           wen_latch,
    input  logic           wen_pin,
    input  logic           prot_clear,
    output logic [AW-1:0]  chk_addr,
    input  logic           chk_deny,
    output logic           busy,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata
);
    pw_op_e                        start_op, op;
    logic                          start, drop, launch_try, launch;
    logic                          word_acc, reject, t_all;
    logic [AW-1:0]                 base;
    logic [CW-1:0]                 count;
    logic [PAGE_WORDS-1:0][DW-1:0] words;

    // Command intake (ignored while busy) and the final start gate.
    always_comb begin
        start    = !busy && (cmd_word || cmd_page || cmd_all);
        start_op = cmd_all ? OP_ALL : (cmd_page ? OP_PAGE : OP_WORD);
        launch   = launch_try && wen_latch && wen_pin && !reject
                   && (op != OP_ALL || prot_clear);
    end

    pw_collect #(.AW(AW), .DW(DW), .PW(PAGE_WORDS)) u_collect (
        .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
        .start_addr(cmd_addr), .word_valid(word_valid && !busy),
        .word_data(word_data), .deny(chk_deny), .drop(drop), .op(op),
        .base(base), .count(count), .words(words), .reject(reject),
        .cur_addr(chk_addr), .word_acc(word_acc)
    );

    pw_window u_window (
        .clk(clk), .rst_n(rst_n), .start(start), .word_acc(word_acc),
        .sclk_rise(sclk_rise), .cs(cs), .active(op != OP_IDLE),
        .busy(busy), .launch_try(launch_try), .drop(drop)
    );

    pw_timer #(.AW(AW), .DW(DW), .PW(PAGE_WORDS), .PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .op(op), .base(base),
        .count(count), .words(words), .busy(busy), .all_mode(t_all),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/pw_prog_seq_chk.sv
// Property checker for pw_prog_seq, bound to every instance of the top.
module pw_prog_seq_chk #(
    parameter int AW          = 6,
    parameter int LW          = 2,
    parameter int PROG_CYCLES = 80
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          cs,
    input logic          sclk_rise,
    input logic          wen_latch,
    input logic          wen_pin,
    input logic          launch,
    input logic          all_mode
);
    logic [31:0] blen_q;

    // Length of the current busy interval in clock cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    blen_q <= '0;
        else if (busy) blen_q <= blen_q + 32'd1;
        else           blen_q <= '0;
    end

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy); // R8
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> blen_q == 32'(PROG_CYCLES)); // R8
    AST_START_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wen_latch && wen_pin)); // R6
    AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(!cs && !sclk_rise)); // R5
    AST_PAGE_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (mem_we && $past(mem_we) && !all_mode) |-> mem_addr[AW-1:LW] == $past(mem_addr[AW-1:LW])); // R3
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !launch); // R9
endmodule

bind pw_prog_seq pw_prog_seq_chk #(.AW(AW), .LW(LW), .PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .cs(cs), .sclk_rise(sclk_rise), .wen_latch(wen_latch), .wen_pin(wen_pin),
    .launch(launch), .all_mode(t_all)
);

// File: tb/pw_prog_seq_bench.sv
module pw_prog_seq_bench;
    localparam int AW = 6, DW = 16, PC = 80, DEPTH = 64;

    typedef struct packed {
        logic [1:0]  op;     // 1 word, 2 page, 3 all
        logic [5:0]  addr;
        logic [2:0]  nw;
        logic [15:0] seed;
        logic        wl, wp;
        logic [6:0]  bound;  // addresses >= bound are protected
        logic        pclr;
        logic [1:0]  tmode;  // 0 in window, 1 early, 2 late
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{2'd1, 6'd5,  3'd1, 16'hA001, 1'b1, 1'b1, 7'd64, 1'b0, 2'd0, 1'b1, 4'd2},  // R2
        '{2'd2, 6'd8,  3'd4, 16'hB010, 1'b1, 1'b1, 7'd64, 1'b0, 2'd0, 1'b1, 4'd3},  // R3
        '{2'd2, 6'd14, 3'd4, 16'hC020, 1'b1, 1'b1, 7'd64, 1'b0, 2'd0, 1'b1, 4'd3},  // R3 wrap
        '{2'd2, 6'd20, 3'd2, 16'hD030, 1'b1, 1'b1, 7'd64, 1'b0, 2'd0, 1'b1, 4'd3},  // R3 partial
        '{2'd1, 6'd6,  3'd1, 16'h1234, 1'b0, 1'b1, 7'd64, 1'b0, 2'd0, 1'b0, 4'd6},  // R6 latch
        '{2'd1, 6'd6,  3'd1, 16'h4321, 1'b1, 1'b0, 7'd64, 1'b0, 2'd0, 1'b0, 4'd6},  // R6 pin
        '{2'd2, 6'd40, 3'd4, 16'h7700, 1'b1, 1'b1, 7'd42, 1'b0, 2'd0, 1'b0, 4'd7},  // R7
        '{2'd3, 6'd0,  3'd1, 16'hE0E0, 1'b1, 1'b1, 7'd64, 1'b0, 2'd0, 1'b0, 4'd4},  // R4 denied
        '{2'd1, 6'd7,  3'd1, 16'h0BAD, 1'b1, 1'b1, 7'd64, 1'b0, 2'd1, 1'b0, 4'd5},  // R5 early
        '{2'd1, 6'd7,  3'd1, 16'h0BAE, 1'b1, 1'b1, 7'd64, 1'b0, 2'd2, 1'b0, 4'd5},  // R5 late
        '{2'd2, 6'd24, 3'd5, 16'h6600, 1'b1, 1'b1, 7'd64, 1'b0, 2'd0, 1'b0, 4'd10}, // R10
        '{2'd3, 6'd0,  3'd1, 16'h5A5A, 1'b1, 1'b1, 7'd64, 1'b1, 2'd0, 1'b1, 4'd4}   // R4
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_word = 0, cmd_page = 0, cmd_all = 0, word_valid = 0, sclk_rise = 0;
    logic cs = 0, wen_latch = 1, wen_pin = 1, prot_clear = 0, chk_deny;
    logic [AW-1:0] cmd_addr = '0, chk_addr, mem_addr;
    logic [DW-1:0] word_data = '0, mem_wdata;
    logic busy, mem_we;
    logic [6:0] prot_bound = 7'd64;
    logic [DW-1:0] mirror [DEPTH];
    logic [DW-1:0] expm [DEPTH];
    int total = 0, bad = 0;

    always #5 clk = ~clk;
    assign chk_deny = ({1'b0, chk_addr} >= prot_bound);

    pw_prog_seq u_pw_prog_seq (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_page(cmd_page),
        .cmd_all(cmd_all), .cmd_addr(cmd_addr), .word_valid(word_valid),
        .word_data(word_data), .sclk_rise(sclk_rise), .cs(cs),
        .wen_latch(wen_latch), .wen_pin(wen_pin), .prot_clear(prot_clear),
        .chk_addr(chk_addr), .chk_deny(chk_deny), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // Bench-side array: captures the write port away from the active edge.
    always @(negedge clk) if (rst_n && mem_we) mirror[mem_addr] = mem_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mem_cmp(input string req);
        int miss = 0, first = -1;
        for (int i = 0; i < DEPTH; i++)
            if (mirror[i] !== expm[i]) begin miss++; if (first < 0) first = i; end
        if (first < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(mirror[first]), int'(expm[first]));
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin @(negedge clk); n++; end
        if (n >= 1000) chk(1'b0, "R8 busy stuck", 1, 0);
    endtask

    task automatic send(input logic [1:0] op, input logic [5:0] addr, input int nw,
                        input logic [15:0] seed, input logic [1:0] tmode);
        @(negedge clk);
        cs = 1; cmd_addr = addr;
        cmd_word = (op == 2'd1); cmd_page = (op == 2'd2); cmd_all = (op == 2'd3);
        @(negedge clk);
        cmd_word = 0; cmd_page = 0; cmd_all = 0;
        for (int i = 0; i < nw; i++) begin
            if (tmode == 2'd1 && i == nw - 1) break;
            sclk_rise = 1; @(negedge clk); sclk_rise = 0; @(negedge clk);
            sclk_rise = 1; word_valid = 1; word_data = seed + 16'(i);
            @(negedge clk);
            sclk_rise = 0; word_valid = 0;
        end
        if (tmode == 2'd2) begin sclk_rise = 1; @(negedge clk); sclk_rise = 0; end
        cs = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mirror[i] = '0; expm[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && mem_we === 1'b0, "R1 reset", {busy, mem_we}, 0);
        rst_n = 1;
        @(negedge clk);

        foreach (VEC[k]) begin
            wen_latch = VEC[k].wl; wen_pin = VEC[k].wp;
            prot_bound = VEC[k].bound; prot_clear = VEC[k].pclr;
            send(VEC[k].op, VEC[k].addr, int'(VEC[k].nw), VEC[k].seed, VEC[k].tmode);
            chk(busy === VEC[k].exp, $sformatf("R%0d start vec%0d", VEC[k].req, k),
                busy, VEC[k].exp);
            wait_idle();
            if (VEC[k].exp) begin
                if (VEC[k].op == 2'd1) expm[VEC[k].addr] = VEC[k].seed;
                else if (VEC[k].op == 2'd3)
                    for (int i = 0; i < DEPTH; i++) expm[i] = VEC[k].seed;
                else
                    for (int i = 0; i < int'(VEC[k].nw) && i < 4; i++)
                        expm[{VEC[k].addr[5:2], VEC[k].addr[1:0] + 2'(i)}] = VEC[k].seed + 16'(i);
            end
            mem_cmp($sformatf("R%0d array vec%0d", VEC[k].req, k));
        end

        // R8: busy length and commit without serial clock
        prot_bound = 7'd64; wen_latch = 1; wen_pin = 1;
        begin
            int blen = 0;
            send(2'd1, 6'd50, 1, 16'h1111, 2'd0);
            while (busy && blen < 1000) begin blen++; @(negedge clk); end
            chk(blen == PC, "R8 busy length", blen, PC);
            expm[50] = 16'h1111;
            mem_cmp("R8 commit");
        end

        // R9: a full command issued while busy is discarded
        send(2'd1, 6'd51, 1, 16'h2222, 2'd0);
        chk(busy === 1'b1, "R9 first start", busy, 1);
        send(2'd1, 6'd52, 1, 16'h3333, 2'd0);
        wait_idle();
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R9 no second cycle", busy, 0);
        expm[51] = 16'h2222;
        mem_cmp("R9 array");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule